// File: doc/BRIEF.md
# Instruction Dispatch Decoder

This block turns a 16-bit instruction word into microroutine start addresses for a microprogrammed 16-bit processor. It works in two separate stages. The first stage searches a loadable opcode table for the instruction and yields the start address of the execution routine, together with the instruction's operand count. The second stage uses a separate loadable table to turn the 3-bit addressing-mode fields into operand-fetch routine addresses.

For a two-operand instruction the source field comes first and the destination field second. For a one-operand instruction, which includes jumps and subroutine calls, only the destination field is dispatched. An instruction without operands skips the mode stage and goes straight to execution. The microsequencer acknowledges each mode dispatch to step the sequence forward.

Both tables are written through plain write ports, so any routine layout can be used by reloading them. An instruction that matches no valid opcode entry is sent to a fixed trap routine address.

Top module: `insn_dispatch`

## Requirements
- R1: After reset `valid_o` and `mode_pend_o` are 0 and `exec_addr_o` is 0. Every opcode entry is invalid, so a load made before any table write gives the trap result.
- R2: A sampled `ir_load_i` makes `valid_o` high for exactly the next clock cycle. `valid_o` is never high without a load in the previous cycle.
- R3: An instruction matches an opcode entry when the entry is valid and `(ir & mask) == (match & mask)`. When several entries match, the entry with the lowest index supplies `exec_addr_o` and `nops_o`, and `hit_o` is 1.
- R4: When no valid entry matches, `exec_addr_o` equals `TRAP_ADDR` (default 0x1F0), `nops_o` is 0 and `hit_o` is 0.
- R5: Instruction bits whose mask bit is 0 have no effect on whether an entry matches.
- R6: With an operand count of 0 (`nops_o` = 0), `mode_pend_o` is 0 in the cycle `valid_o` is high.
- R7: With an operand count of 2, `mode_field_o` is 0 (source) first. At that point `mode_addr_o` holds mode-table entry {0, ir[11:9]}. After one `mode_ack_i` it is 1 (destination) and `mode_addr_o` holds entry {1, ir[5:3]}. After a second acknowledge `mode_pend_o` falls.
- R8: With an operand count of 1 (one-operand arithmetic, jumps and calls), the sequence starts at the destination field with entry {1, ir[5:3]}. One acknowledge ends it.
- R9: Rewriting an opcode entry changes the dispatch of later loads. The registered outputs `exec_addr_o`, `nops_o` and `hit_o` hold their values until the next load.
- R10: `mode_ack_i` has no effect while `mode_pend_o` is 0. A load while a sequence is pending restarts the sequence from the new instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ir_load_i | input | 1 | Instruction register load strobe |
| ir_i | input | 16 | Instruction word |
| op_we_i | input | 1 | Opcode table write enable |
| op_idx_i | input | 6 | Opcode entry index; a lower index has higher priority |
| op_vld_i | input | 1 | Valid bit written to the entry |
| op_match_i | input | 16 | Match pattern |
| op_mask_i | input | 16 | Care mask; a 1 bit is compared |
| op_addr_i | input | 9 | Execution routine address |
| op_nops_i | input | 2 | Operand count: 0, 1 or 2 |
| md_we_i | input | 1 | Mode table write enable |
| md_idx_i | input | 4 | Mode entry index: {field 0=src 1=dst, mode[2:0]} |
| md_addr_i | input | 9 | Operand-fetch routine address |
| mode_ack_i | input | 1 | Sequencer has taken the current mode dispatch |
| valid_o | output | 1 | One-cycle strobe after a load |
| exec_addr_o | output | 9 | Execution routine start address |
| nops_o | output | 2 | Operand count of the decoded instruction |
| hit_o | output | 1 | 1 when an opcode entry matched |
| mode_pend_o | output | 1 | A mode dispatch is pending |
| mode_field_o | output | 1 | Current field: 0 source, 1 destination |
| mode_addr_o | output | 9 | Operand-fetch routine address for the current field |

## Verification
The bound checker watches the one-cycle load strobe on every cycle. It also checks that a miss always carries the trap address, that each operand count starts at the right field, that every acknowledge moves the sequence source to destination to idle, and that the registered outputs stay still between loads. What the properties cannot see is which entry value comes out: first-match priority among overlapping entries, don't-care bits, the exact mode-table address for each field, and the effect of reprogramming. The bench scenarios show these against a table model held in the bench.

// File: rtl/insn_dispatch_pkg.sv
package insn_dispatch_pkg;
  typedef enum logic {
    FLD_SRC = 1'b0,
    FLD_DST = 1'b1
  } fld_e;

  localparam int unsigned NOPS_W = 2;
endpackage

// File: rtl/op_table.sv
module op_table #(
  parameter int unsigned IW   = 16,
  parameter int unsigned AW   = 9,
  parameter int unsigned NENT = 64,
  parameter int unsigned NW   = 2,
  parameter logic [AW-1:0] TRAP_ADDR = '1,
  localparam int unsigned XW = $clog2(NENT)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [XW-1:0] idx_i,
  input  logic          vld_i,
  input  logic [IW-1:0] match_i,
  input  logic [IW-1:0] mask_i,
  input  logic [AW-1:0] addr_i,
  input  logic [NW-1:0] nops_i,
  input  logic [IW-1:0] ir_i,
  output logic          hit_o,
  output logic [AW-1:0] addr_o,
  output logic [NW-1:0] nops_o
);
  logic [NENT-1:0] vld_q;
  logic [IW-1:0]   match_q [NENT];
  logic [IW-1:0]   mask_q  [NENT];
  logic [AW-1:0]   addr_q  [NENT];
  logic [NW-1:0]   nops_q  [NENT];
  logic [NENT-1:0] hit_vec;

  for (genvar e = 0; e < NENT; e++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        vld_q[e]   <= 1'b0;
        match_q[e] <= '0;
        mask_q[e]  <= '0;
        addr_q[e]  <= '0;
        nops_q[e]  <= '0;
      end else if (we_i && idx_i == XW'(e)) begin
        vld_q[e]   <= vld_i;
        match_q[e] <= match_i;
        mask_q[e]  <= mask_i;
        addr_q[e]  <= addr_i;
        nops_q[e]  <= nops_i;
      end
    end
    assign hit_vec[e] = vld_q[e] && ((ir_i & mask_q[e]) == (match_q[e] & mask_q[e]));
  end

  // walk from the top so the lowest matching index is assigned last
  always_comb begin
    hit_o  = 1'b0;
    addr_o = TRAP_ADDR;
    nops_o = '0;
    for (int e = NENT - 1; e >= 0; e--) begin
      if (hit_vec[e]) begin
        hit_o  = 1'b1;
        addr_o = addr_q[e];
        nops_o = nops_q[e];
      end
    end
  end
endmodule

// File: rtl/mode_table.sv
module mode_table #(
  parameter int unsigned AW = 9,
  parameter int unsigned MW = 3,
  localparam int unsigned XW = MW + 1,
  localparam int unsigned NM = 1 << XW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [XW-1:0] idx_i,
  input  logic [AW-1:0] addr_i,
  input  logic [MW-1:0] src_mode_i,
  input  logic [MW-1:0] dst_mode_i,
  output logic [AW-1:0] src_addr_o,
  output logic [AW-1:0] dst_addr_o
);
  logic [AW-1:0] tab_q [NM];

  for (genvar m = 0; m < NM; m++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                            tab_q[m] <= '0;
      else if (we_i && idx_i == XW'(m))       tab_q[m] <= addr_i;
    end
  end

  assign src_addr_o = tab_q[{1'b0, src_mode_i}];
  assign dst_addr_o = tab_q[{1'b1, dst_mode_i}];
endmodule

// File: rtl/mode_seq.sv
module mode_seq
  import insn_dispatch_pkg::*;
#(
  parameter int unsigned AW = 9,
  parameter int unsigned MW = 3,
  parameter int unsigned NW = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [NW-1:0] nops_i,
  input  logic [MW-1:0] dst_mode_i,
  input  logic [AW-1:0] src_addr_i,
  input  logic [AW-1:0] dst_addr_i,
  input  logic          ack_i,
  output logic [MW-1:0] dst_mode_o,
  output logic          pend_o,
  output fld_e          field_o,
  output logic [AW-1:0] addr_o
);
  logic          pend_q;
  fld_e          field_q;
  logic [AW-1:0] addr_q;
  logic [MW-1:0] dst_q;
  logic          two_ops;

  assign two_ops = nops_i >= NW'(2);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q  <= 1'b0;
      field_q <= FLD_SRC;
      addr_q  <= '0;
      dst_q   <= '0;
    end else if (load_i) begin
      pend_q  <= nops_i != '0;
      field_q <= two_ops ? FLD_SRC : FLD_DST;
      addr_q  <= two_ops ? src_addr_i : dst_addr_i;
      dst_q   <= dst_mode_i;
    end else if (ack_i && pend_q) begin
      if (field_q == FLD_SRC) begin
        field_q <= FLD_DST;
        addr_q  <= dst_addr_i;
      end else begin
        pend_q  <= 1'b0;
      end
    end
  end

  assign dst_mode_o = dst_q;
  assign pend_o     = pend_q;
  assign field_o    = field_q;
  assign addr_o     = addr_q;
endmodule

// File: rtl/insn_dispatch.sv
module insn_dispatch
  import insn_dispatch_pkg::*;
#(
  parameter int unsigned IW      = 16,
  parameter int unsigned AW      = 9,
  parameter int unsigned NENT    = 64,
  parameter int unsigned MW      = 3,
  parameter int unsigned SRC_LSB = 9,
  parameter int unsigned DST_LSB = 3,
  parameter logic [AW-1:0] TRAP_ADDR = 9'h1F0,
  localparam int unsigned XW = $clog2(NENT),
  localparam int unsigned NW = NOPS_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ir_load_i,
  input  logic [IW-1:0] ir_i,
  input  logic          op_we_i,
  input  logic [XW-1:0] op_idx_i,
  input  logic          op_vld_i,
  input  logic [IW-1:0] op_match_i,
  input  logic [IW-1:0] op_mask_i,
  input  logic [AW-1:0] op_addr_i,
  input  logic [NW-1:0] op_nops_i,
  input  logic          md_we_i,
  input  logic [MW:0]   md_idx_i,
  input  logic [AW-1:0] md_addr_i,
  input  logic          mode_ack_i,
  output logic          valid_o,
  output logic [AW-1:0] exec_addr_o,
  output logic [NW-1:0] nops_o,
  output logic          hit_o,
  output logic          mode_pend_o,
  output logic          mode_field_o,
  output logic [AW-1:0] mode_addr_o
);
  logic          lk_hit;
  logic [AW-1:0] lk_addr;
  logic [NW-1:0] lk_nops;
  logic [AW-1:0] src_addr, dst_addr;
  logic [MW-1:0] dst_sel, dst_held;
  fld_e          field;

  op_table #(.IW(IW), .AW(AW), .NENT(NENT), .NW(NW), .TRAP_ADDR(TRAP_ADDR)) u_op (
    .clk_i, .rst_ni,
    .we_i(op_we_i), .idx_i(op_idx_i), .vld_i(op_vld_i), .match_i(op_match_i),
    .mask_i(op_mask_i), .addr_i(op_addr_i), .nops_i(op_nops_i),
    .ir_i, .hit_o(lk_hit), .addr_o(lk_addr), .nops_o(lk_nops)
  );

  // on a load the destination lookup uses the incoming word, afterwards the held field
  assign dst_sel = ir_load_i ? ir_i[DST_LSB +: MW] : dst_held;

  mode_table #(.AW(AW), .MW(MW)) u_md (
    .clk_i, .rst_ni,
    .we_i(md_we_i), .idx_i(md_idx_i), .addr_i(md_addr_i),
    .src_mode_i(ir_i[SRC_LSB +: MW]), .dst_mode_i(dst_sel),
    .src_addr_o(src_addr), .dst_addr_o(dst_addr)
  );

  mode_seq #(.AW(AW), .MW(MW), .NW(NW)) u_seq (
    .clk_i, .rst_ni,
    .load_i(ir_load_i), .nops_i(lk_nops), .dst_mode_i(ir_i[DST_LSB +: MW]),
    .src_addr_i(src_addr), .dst_addr_i(dst_addr), .ack_i(mode_ack_i),
    .dst_mode_o(dst_held), .pend_o(mode_pend_o), .field_o(field), .addr_o(mode_addr_o)
  );

  assign mode_field_o = field;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o     <= 1'b0;
      exec_addr_o <= '0;
      nops_o      <= '0;
      hit_o       <= 1'b0;
    end else begin
      valid_o <= ir_load_i;
      if (ir_load_i) begin
        exec_addr_o <= lk_addr;
        nops_o      <= lk_nops;
        hit_o       <= lk_hit;
      end
    end
  end
endmodule

// File: rtl/insn_dispatch_chk.sv
module insn_dispatch_chk #(
  parameter int unsigned AW = 9,
  parameter logic [AW-1:0] TRAP_ADDR = 9'h1F0
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          ir_load_i,
  input logic          mode_ack_i,
  input logic          valid_o,
  input logic [AW-1:0] exec_addr_o,
  input logic [1:0]    nops_o,
  input logic          hit_o,
  input logic          mode_pend_o,
  input logic          mode_field_o
);
  AST_LOAD_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ir_load_i |=> valid_o); // R2
  AST_NO_STRAY_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ir_load_i |=> !valid_o); // R2
  AST_MISS_TRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && !hit_o |-> exec_addr_o == TRAP_ADDR && nops_o == 2'd0); // R4
  AST_ZERO_OPS_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && nops_o == 2'd0 |-> !mode_pend_o); // R6
  AST_SRC_FIRST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && nops_o >= 2'd2 |-> mode_pend_o && !mode_field_o); // R7
  AST_SRC_TO_DST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_pend_o && !mode_field_o && mode_ack_i && !ir_load_i |=> mode_pend_o && mode_field_o); // R7
  AST_DST_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_pend_o && mode_field_o && mode_ack_i && !ir_load_i |=> !mode_pend_o); // R7
  AST_ONE_OP_DST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && nops_o == 2'd1 |-> mode_pend_o && mode_field_o); // R8
  AST_HOLD_EXEC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ir_load_i |=> $stable(exec_addr_o) && $stable(nops_o) && $stable(hit_o)); // R9
  AST_IDLE_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mode_pend_o && !ir_load_i |=> !mode_pend_o); // R10
endmodule

bind insn_dispatch insn_dispatch_chk #(.AW(AW), .TRAP_ADDR(TRAP_ADDR)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .ir_load_i(ir_load_i), .mode_ack_i(mode_ack_i),
  .valid_o(valid_o), .exec_addr_o(exec_addr_o), .nops_o(nops_o), .hit_o(hit_o),
  .mode_pend_o(mode_pend_o), .mode_field_o(mode_field_o)
);

// File: tb/insn_dispatch_test.sv
module insn_dispatch_test;
  localparam logic [8:0] TRAP = 9'h1F0;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        ir_load_i = 1'b0;
  logic [15:0] ir_i = '0;
  logic        op_we_i = 1'b0;
  logic [5:0]  op_idx_i = '0;
  logic        op_vld_i = 1'b0;
  logic [15:0] op_match_i = '0, op_mask_i = '0;
  logic [8:0]  op_addr_i = '0;
  logic [1:0]  op_nops_i = '0;
  logic        md_we_i = 1'b0;
  logic [3:0]  md_idx_i = '0;
  logic [8:0]  md_addr_i = '0;
  logic        mode_ack_i = 1'b0;
  logic        valid_o, hit_o, mode_pend_o, mode_field_o;
  logic [8:0]  exec_addr_o, mode_addr_o;
  logic [1:0]  nops_o;

  int total = 0, bad = 0;
  bit done = 1'b0;

  always #5 clk_i = ~clk_i;

  insn_dispatch uut (.*);

  // bench-side table model
  logic        r_vld [64];
  logic [15:0] r_match [64], r_mask [64];
  logic [8:0]  r_addr [64];
  logic [1:0]  r_nops [64];
  logic [8:0]  r_md [16];

  typedef struct { logic [8:0] addr; logic [1:0] nops; logic hit; string tag; } exp_t;
  exp_t exp_q[$];

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic exp_t ref_lookup(input logic [15:0] w, input string tag);
    exp_t x;
    x.addr = TRAP; x.nops = 2'd0; x.hit = 1'b0; x.tag = tag;
    for (int e = 63; e >= 0; e--)
      if (r_vld[e] && ((w & r_mask[e]) == (r_match[e] & r_mask[e]))) begin
        x.addr = r_addr[e]; x.nops = r_nops[e]; x.hit = 1'b1;
      end
    return x;
  endfunction

  // monitor: pops one expected item per valid strobe
  always @(negedge clk_i) begin
    if (rst_ni && valid_o) begin
      if (exp_q.size() == 0) begin
        chk("R2 unexpected valid", 32'(valid_o), 32'd0);
      end else begin
        exp_t x;
        x = exp_q.pop_front();
        chk({x.tag, " exec_addr"}, 32'(exec_addr_o), 32'(x.addr));
        chk({x.tag, " nops"},      32'(nops_o),      32'(x.nops));
        chk({x.tag, " hit"},       32'(hit_o),       32'(x.hit));
      end
    end
  end

  task automatic wr_op(input int i, input logic [15:0] m, input logic [15:0] k,
                       input logic [8:0] a, input logic [1:0] n);
    r_vld[i] = 1'b1; r_match[i] = m; r_mask[i] = k; r_addr[i] = a; r_nops[i] = n;
    op_we_i = 1'b1; op_idx_i = 6'(i); op_vld_i = 1'b1;
    op_match_i = m; op_mask_i = k; op_addr_i = a; op_nops_i = n;
    @(negedge clk_i);
    op_we_i = 1'b0;
  endtask

  task automatic wr_md(input int i, input logic [8:0] a);
    r_md[i] = a;
    md_we_i = 1'b1; md_idx_i = 4'(i); md_addr_i = a;
    @(negedge clk_i);
    md_we_i = 1'b0;
  endtask

  // driver: returns at the negedge where valid_o is high
  task automatic load_ir(input logic [15:0] w, input string tag);
    exp_q.push_back(ref_lookup(w, tag));
    ir_i = w; ir_load_i = 1'b1;
    @(negedge clk_i);
    ir_load_i = 1'b0;
  endtask

  task automatic ack();
    mode_ack_i = 1'b1;
    @(negedge clk_i);
    mode_ack_i = 1'b0;
  endtask

  task automatic chk_mode(input string req, input logic p, input logic f, input logic [8:0] a);
    chk({req, " pend"}, 32'(mode_pend_o), 32'(p));
    if (p) begin
      chk({req, " field"}, 32'(mode_field_o), 32'(f));
      chk({req, " addr"},  32'(mode_addr_o),  32'(a));
    end
  endtask

  initial begin
    for (int e = 0; e < 64; e++) begin
      r_vld[e] = 1'b0; r_match[e] = '0; r_mask[e] = '0; r_addr[e] = '0; r_nops[e] = '0;
    end
    for (int m = 0; m < 16; m++) r_md[m] = '0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R1 reset state and empty table
    chk("R1 valid", 32'(valid_o), 32'd0);
    chk("R1 pend", 32'(mode_pend_o), 32'd0);
    chk("R1 exec", 32'(exec_addr_o), 32'd0);
    load_ir(16'h1234, "R1 empty table");
    @(negedge clk_i);
    chk("R2 strobe low", 32'(valid_o), 32'd0);

    for (int m = 0; m < 16; m++) wr_md(m, 9'h100 + 9'(m * 3));
    wr_op(0, 16'h1000, 16'hF000, 9'h020, 2'd2); // two-operand move class
    wr_op(1, 16'h0A80, 16'hFFC0, 9'h040, 2'd1); // one-operand increment
    wr_op(2, 16'h0000, 16'hFFFF, 9'h060, 2'd0); // halt, no operands
    wr_op(3, 16'h0040, 16'hFFC0, 9'h080, 2'd1); // jump
    wr_op(4, 16'h0A00, 16'hFF00, 9'h0A0, 2'd1); // broad, overlaps entry 1

    // R7 two operands: src mode 3, dst mode 5
    load_ir(16'h1629, "R7 move");
    chk_mode("R7 src", 1'b1, 1'b0, r_md[3]);
    ack();
    chk_mode("R7 dst", 1'b1, 1'b1, r_md[8 + 5]);
    ack();
    chk_mode("R7 end", 1'b0, 1'b0, '0);
    // R10 ack while idle
    ack();
    chk_mode("R10 idle ack", 1'b0, 1'b0, '0);

    // R3 overlap, lowest index wins; R5 don't-care bits
    load_ir(16'h0A95, "R3 inc");
    chk_mode("R8 inc dst", 1'b1, 1'b1, r_md[8 + 2]);
    ack();
    chk_mode("R8 end", 1'b0, 1'b0, '0);
    load_ir(16'h0A47, "R5 broad entry");
    load_ir(16'h1FFF, "R5 move any fields");

    // R8 jump reuses the destination mode path
    load_ir(16'h0077, "R8 jump");
    chk_mode("R8 jump dst", 1'b1, 1'b1, r_md[8 + 6]);

    // R10 load while pending restarts
    load_ir(16'h1E08, "R10 reload");
    chk_mode("R10 restart src", 1'b1, 1'b0, r_md[7]);

    // R6 zero operands
    load_ir(16'h0000, "R6 halt");
    chk_mode("R6 no mode", 1'b0, 1'b0, '0);

    // R4 miss
    load_ir(16'hFFFF, "R4 miss");
    chk_mode("R4 no mode", 1'b0, 1'b0, '0);

    // R9 hold under table write, then reprogram
    wr_op(2, 16'h0000, 16'hFFFF, 9'h070, 2'd0);
    chk("R9 hold exec", 32'(exec_addr_o), 32'(TRAP));
    chk("R9 hold hit", 32'(hit_o), 32'd0);
    load_ir(16'h0000, "R9 reprogrammed");
    @(negedge clk_i);
    chk("R2 strobe low end", 32'(valid_o), 32'd0);
    chk("R2 queue drained", 32'(exp_q.size()), 32'd0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      total++; bad++;
      $display("FAIL R2 watchdog act=hung exp=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule